// File: doc/BRIEF.md
# Descriptor-Queued SPI Master

This block is an SPI master in mode 0 (clock idles low, data sampled on the rising edge) that works through a short list of transfer descriptors without help from the processor. Each of the eight descriptor slots holds four values: a transmit word, the index of the peripheral to select, a bit count from 1 to 16, and a settling delay. The processor writes these slots through a small register port, sets the serial clock rate and the index of the final entry, and then issues a start. The controller then runs the entries in order. For each entry it drives one active-low select, shifts the word out most significant bit first while it shifts the reply in, and stores the reply in a receive slot that has the same index as the entry.

When a pass ends, one of two things happens. Without wrap, the controller raises a done flag, releases every select and goes idle. With wrap, it starts again at entry zero and keeps going with no gaps, so it can poll a converter continuously. The processor reads each fresh sample from its receive slot. It may rewrite descriptors while the queue runs, and it stops the polling by clearing the wrap bit, which lets the current pass finish first.

Top module: `spi_queue_master`

## Requirements
- R1: After reset every select is high, the serial clock and the transmit line are low, the status reads 0, and all eight receive slots read 0.
- R2: Register port. Writes to addresses 0 to 7 fill a descriptor: bits [15:0] hold the transmit word, [17:16] the select index, [21:18] the bit count minus one, and [29:22] the delay D. A write to address 8 is control: bits [7:0] hold the half-period H (0 counts as 1), [10:8] the index of the last entry, bit 11 the wrap flag, and bit 12 the start request. Reads of addresses 0 to 7 return receive slots. A read of address 8 returns status, with bit 0 = busy and bit 1 = done.
- R3: Entries run in the order 0, 1, … up to the last index, exactly one transfer each. During a transfer only cs_n[index] is low, and it stays the same throughout. All selects return high between entries.
- R4: The serial clock is low whenever no device is selected. Its period is 2·max(H,1) system clocks, and each transfer gives exactly (count field + 1) rising edges.
- R5: The transmit line carries the low n bits of the transmit word, most significant first, and changes only while the serial clock is low.
- R6: The first rising clock edge comes exactly (D+1)·2·max(H,1) system clocks after the select falls.
- R7: The receive line is sampled on each rising edge. The n bits are placed right-aligned and zero-filled into the slot of that entry. A read of the slot shows the new word from the same clock edge that releases the select, and the old word before that edge.
- R8: Without wrap, once the last entry ends, status reads done=1 and busy=0 and all selects are high. Slots above the last index keep their earlier contents. A new start clears done.
- R9: With wrap set, entry 0 follows the last entry, and status stays busy=1 and done=0. If wrap is cleared during a run, the current pass still finishes on the last entry, and the controller then stops with done=1.
- R10: A start request while busy changes neither the order nor the number of transfers in the current run.
- R11: A descriptor rewritten during a run takes effect the next time that entry is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address (0-7 slots, 8 control/status) |
| bus_wdata | input | 30 | Register write data |
| bus_rdata | output | 16 | Register read data, combinational from bus_addr |
| sclk | output | 1 | Serial clock, mode 0 |
| mosi | output | 1 | Serial data to peripherals |
| miso | input | 1 | Serial data from peripherals |
| cs_n | output | 4 | Active-low peripheral selects |

## Verification
Two things can happen in the same clock cycle. The sequencer writes a received word into a slot, and the processor reads that same slot through the combinational read port. To create this overlap, the bench holds the read address on slot 0 while a one-entry queue runs, and it samples the port every cycle. Just before the select rises the read must still return the old word, and in the cycle the select is high again it must return the new one. A second overlap is a control write that clears wrap while a pass is in flight. This case is judged by requiring the run to end on the last entry rather than part-way through a pass.

// File: rtl/spi_queue_master.sv
module spi_queue_master #(
  parameter int DEPTH = 8,
  parameter int DW = 16,
  parameter int NCS = 4,
  parameter int DLYW = 8,
  parameter int HALFW = 8,
  localparam int IW = $clog2(DEPTH),
  localparam int CW = $clog2(NCS),
  localparam int LW = $clog2(DW),
  localparam int AW = IW + 1,
  localparam int DESCW = DW + CW + LW + DLYW,
  localparam int CTLW = HALFW + IW + 2,
  localparam int WW = (DESCW > CTLW) ? DESCW : CTLW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [WW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic           sclk,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_SETUP, S_SHIFT} st_t;

  st_t               st;
  logic [DESCW-1:0]  desc [DEPTH];
  logic [DW-1:0]     rxq  [DEPTH];
  logic [IW-1:0]     ptr, last_q;
  logic [HALFW-1:0]  half_q, cnt;
  logic              wrap_q, done_q, sclk_q;
  logic [DLYW:0]     tcnt;
  logic [LW-1:0]     bitn, len_q;
  logic [CW-1:0]     sel;
  logic [DLYW-1:0]   dly_q;
  logic [DW-1:0]     sh, rx;

  wire slot_acc = bus_addr < AW'(DEPTH);
  wire ctl_wr   = bus_we && (bus_addr == AW'(DEPTH));
  wire start    = ctl_wr && bus_wdata[HALFW+IW+1] && (st == S_IDLE);
  wire active   = (st == S_SETUP) || (st == S_SHIFT);
  wire busy     = st != S_IDLE;
  wire [HALFW-1:0] hlim = (half_q == '0) ? HALFW'(1) : half_q;
  wire tick = cnt == hlim - 1'b1;
  wire [DESCW-1:0] cur = desc[ptr];
  wire [LW-1:0] cur_len = cur[DW+CW+LW-1:DW+CW];

  assign sclk = sclk_q;
  assign mosi = active ? sh[DW-1] : 1'b0;
  assign cs_n = active ? ~(NCS'(1) << sel) : '1;
  assign bus_rdata = slot_acc ? rxq[bus_addr[IW-1:0]] : DW'({done_q, busy});

  always_ff @(posedge clk)
    if (bus_we && slot_acc) desc[bus_addr[IW-1:0]] <= bus_wdata[DESCW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ptr <= '0;
      last_q <= '0;
      half_q <= HALFW'(1);
      wrap_q <= 1'b0;
      done_q <= 1'b0;
      cnt <= '0;
      tcnt <= '0;
      bitn <= '0;
      len_q <= '0;
      sel <= '0;
      dly_q <= '0;
      sh <= '0;
      rx <= '0;
      sclk_q <= 1'b0;
      for (int i = 0; i < DEPTH; i++) rxq[i] <= '0;
    end else begin
      if (ctl_wr) begin
        half_q <= bus_wdata[HALFW-1:0];
        last_q <= bus_wdata[HALFW+IW-1:HALFW];
        wrap_q <= bus_wdata[HALFW+IW];
      end
      cnt <= (active && !tick) ? cnt + 1'b1 : '0;
      case (st)
        S_IDLE: if (start) begin
          done_q <= 1'b0;
          ptr <= '0;
          st <= S_LOAD;
        end
        S_LOAD: begin
          sh <= cur[DW-1:0] << (LW'(DW - 1) - cur_len);
          sel <= cur[DW+CW-1:DW];
          len_q <= cur_len;
          dly_q <= cur[DESCW-1:DW+CW+LW];
          rx <= '0;
          tcnt <= '0;
          bitn <= '0;
          sclk_q <= 1'b0;
          st <= S_SETUP;
        end
        S_SETUP: if (tick) begin
          if (tcnt == {dly_q, 1'b0}) st <= S_SHIFT;
          else tcnt <= tcnt + 1'b1;
        end
        S_SHIFT: if (tick) begin
          if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx <= {rx[DW-2:0], miso};
          end else begin
            sclk_q <= 1'b0;
            sh <= sh << 1;
            bitn <= bitn + 1'b1;
            if (bitn == len_q) begin
              rxq[ptr] <= rx;
              if (ptr != last_q) begin
                ptr <= ptr + 1'b1;
                st <= S_LOAD;
              end else if (wrap_q) begin
                ptr <= '0;
                st <= S_LOAD;
              end else begin
                done_q <= 1'b1;
                st <= S_IDLE;
              end
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/spi_queue_master_chk.sv
module spi_queue_master_chk #(
  parameter int NCS = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk,
  input logic           mosi,
  input logic [NCS-1:0] cs_n,
  input logic           done
);

  p_one_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));

  p_sel_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n != '1) |=> (cs_n == '1 || $stable(cs_n)));

  p_clk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n == '1) |-> !sclk);

  p_clk_rise_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> (cs_n != '1));

  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(mosi));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n == '1 && !sclk));

endmodule

bind spi_queue_master spi_queue_master_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .done(done_q)
);

// File: tb/spi_queue_master_test.sv
module spi_queue_master_test;
  logic        clk = 0, rst_n = 0, we = 0, miso = 0;
  logic [3:0]  addr = 0;
  logic [29:0] wdata = 0;
  logic [15:0] rdata;
  logic        sclk, mosi;
  logic [3:0]  cs_n;

  always #4 clk = ~clk;

  spi_queue_master uut (.clk(clk), .rst_n(rst_n), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
                        .bus_rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n));

  int total = 0, bad = 0, cur_h = 1, k = 0;
  int mon_cs[256], mon_nb[256], mon_setup[256], mon_word[256];
  bit mon_oh[256], mon_per[256], mon_chg[256];
  int tb_tx[8], tb_cs[8], tb_n[8], tb_d[8], exp_slot[8];

  function automatic int pat(int kk);
    return (32'hB4E1 ^ (kk * 40503)) & 32'hFFFF;
  endfunction

  logic [3:0] pcs = 4'hF;
  logic psclk = 0, perbad = 0, chg = 0;
  logic [15:0] w = 0, sreg = 0;
  int cyc = 0, tfall = 0, lastrise = 0, nb = 0;

  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (pcs == 4'hF && cs_n != 4'hF) begin
      int c = 0;
      for (int i = 0; i < 4; i++) if (!cs_n[i]) c = i;
      tfall = cyc; w = 0; nb = 0; perbad = 0; chg = 0;
      sreg = 16'(pat(k)); miso = sreg[15];
      if (k < 256) begin mon_oh[k] = ($countones(~cs_n) == 1); mon_cs[k] = c; end
    end
    if (pcs != 4'hF && cs_n != 4'hF) begin
      if (cs_n != pcs) chg = 1;
      if (!psclk && sclk) begin
        if (nb == 0) begin if (k < 256) mon_setup[k] = cyc - tfall; end
        else if (cyc - lastrise != 2 * cur_h) perbad = 1;
        lastrise = cyc; w = {w[14:0], mosi}; nb++;
      end
      if (psclk && !sclk) begin sreg = {sreg[14:0], 1'b0}; miso = sreg[15]; end
    end
    if (pcs != 4'hF && cs_n == 4'hF) begin
      if (k < 256) begin mon_word[k] = w; mon_nb[k] = nb; mon_per[k] = perbad; mon_chg[k] = chg; end
      k++;
    end
    pcs = cs_n; psclk = sclk;
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk); addr = 4'(a); wdata = 30'(d); we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); addr = 4'(a); #1; v = int'(rdata);
  endtask

  task automatic set_desc(int e, int tx, int cs, int n, int d);
    tb_tx[e] = tx & 16'hFFFF; tb_cs[e] = cs; tb_n[e] = n; tb_d[e] = d;
    wr(e, (d << 22) | ((n - 1) << 18) | (cs << 16) | (tx & 16'hFFFF));
  endtask

  task automatic ctl(int half, int last, int wrap, int go);
    wr(8, (go << 12) | (wrap << 11) | (last << 8) | half);
  endtask

  task automatic wait_done();
    int v;
    do rd(8, v); while ((v & 2) == 0);
  endtask

  task automatic wait_xfers(int target);
    while (k < target) @(negedge clk);
  endtask

  task automatic verify(int kk, int e);
    int n = tb_n[e];
    chk($sformatf("R3 select index xfer %0d", kk), mon_cs[kk], tb_cs[e]);
    chk($sformatf("R3 single select xfer %0d", kk), int'(mon_oh[kk]), 1);
    chk($sformatf("R3 select steady xfer %0d", kk), int'(mon_chg[kk]), 0);
    chk($sformatf("R4 edge count xfer %0d", kk), mon_nb[kk], n);
    chk($sformatf("R4 clock period xfer %0d", kk), int'(mon_per[kk]), 0);
    chk($sformatf("R5 mosi word xfer %0d", kk), mon_word[kk], tb_tx[e] & ((32'd1 << n) - 1));
    chk($sformatf("R6 setup time xfer %0d", kk), mon_setup[kk], (tb_d[e] + 1) * 2 * cur_h);
    exp_slot[e] = pat(kk) >> (16 - n);
  endtask

  task automatic check_slots(string tag);
    int v;
    for (int e = 0; e < 8; e++) begin
      rd(e, v);
      chk($sformatf("%s slot %0d", tag, e), v, exp_slot[e]);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R3 watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int v, k0, k1, kk, old, newv, prev, cur;
    int halves[3] = '{0, 1, 3};
    bit seen;
    for (int e = 0; e < 8; e++) exp_slot[e] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 selects idle", int'(cs_n), 'hF);
    chk("R1 sclk low", int'(sclk), 0);
    chk("R1 mosi low", int'(mosi), 0);
    rd(8, v); chk("R1 status", v, 0);
    check_slots("R1");

    for (int p = 0; p < 3; p++) begin
      cur_h = (halves[p] == 0) ? 1 : halves[p];
      for (int e = 0; e < 8; e++)
        set_desc(e, (e * 16'h1F3D) ^ (p * 16'h7A21) ^ 16'hC35A, (e + p) % 4, (p * 8 + e) % 16 + 1, (e * 3 + p) % 4);
      k0 = k;
      ctl(halves[p], 7, 0, 1);
      wait_done();
      chk("R3 transfers per pass", k - k0, 8);
      for (int e = 0; e < 8; e++) verify(k0 + e, e);
      rd(8, v); chk("R2 R8 status done idle", v, 2);
      chk("R8 selects released", int'(cs_n), 'hF);
      check_slots("R7");
    end

    cur_h = 1;
    for (int e = 0; e < 3; e++) set_desc(e, 16'h9E37 + e * 16'h1111, 3 - e, 5 + e * 4, e);
    k0 = k;
    ctl(1, 2, 0, 1);
    wait_done();
    chk("R8 short queue count", k - k0, 3);
    for (int e = 0; e < 3; e++) verify(k0 + e, e);
    check_slots("R8 upper slots kept");

    cur_h = 2;
    for (int e = 0; e < 4; e++) set_desc(e, 16'h2468 ^ (e << 12), e, 6 + e, 1);
    k0 = k;
    ctl(2, 3, 0, 1);
    wait_xfers(k0 + 1);
    ctl(2, 3, 0, 1);
    wait_done();
    chk("R10 start while busy count", k - k0, 4);
    for (int e = 0; e < 4; e++) verify(k0 + e, e);

    cur_h = 1;
    set_desc(0, 16'hACE1, 2, 12, 0);
    set_desc(1, 16'h0F0F, 1, 7, 2);
    k0 = k;
    ctl(1, 1, 1, 1);
    wait_xfers(k0 + 5);
    rd(8, v); chk("R9 wrap keeps busy", v, 1);
    for (int i = 0; i < 5; i++) verify(k0 + i, i % 2);
    set_desc(0, 16'h5B3D, 2, 12, 0);
    k1 = k;
    wait_xfers(k1 + 3);
    kk = k0;
    for (int i = k0; i < k; i++) if ((i - k0) % 2 == 0) kk = i;
    chk("R11 rewritten descriptor used", mon_word[kk], 16'h5B3D & 16'h0FFF);
    ctl(1, 1, 0, 0);
    wait_done();
    chk("R9 run ends on last entry", (k - k0) % 2, 0);
    verify(k - 2, 0);
    verify(k - 1, 1);
    check_slots("R9");

    cur_h = 2;
    set_desc(0, 16'h5AC3, 1, 8, 1);
    old = exp_slot[0];
    k0 = k;
    newv = pat(k0) >> 8;
    ctl(2, 0, 0, 1);
    prev = -1; cur = -1; seen = 0;
    while (1) begin
      @(negedge clk); addr = 0; #1;
      cur = int'(rdata);
      if (cs_n != 4'hF) seen = 1;
      else if (seen) break;
      prev = cur;
    end
    chk("R7 slot old before release", prev, old);
    chk("R7 slot new at release", cur, newv);
    wait_done();
    verify(k0, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule